// File: doc/BRIEF.md
# Low-Power-Domain Real-Time Clock Register Block

This block is the bus-facing side of a real-time clock whose timekeeping lives in a slow, always-on domain. A 47-bit counter advances once per 32 kHz tick. Its upper 32 bits count whole seconds and its lower 15 bits count the fraction of a second. Next to the counter sit an alarm compare value, a control word, a status word and an interrupt-enable word, all reached through a simple synchronous read/write port.

The slow domain is modelled by `tick_i`, a one-cycle strobe in the bus clock that marks each 32 kHz edge. Any write other than an interrupt-enable write is first latched as a single pending transfer. On the next tick that transfer lands in the slow domain, and software sees it finish through a write-complete status flag that is cleared when the status word is read. Interrupt-enable writes take effect at bus speed. A single level interrupt reports every enabled flag that is set.

Top module: `rtc_lp_regs`

## Requirements
- R1: After reset the status word at 0x14 reads 0x202 (non-valid bit 1 and write-next bit 9 set), control at 0x10 and interrupt enable at 0x18 read 0, both counter words read 0, alarm seconds at 0x08 read 0xFFFFFFFF, alarm fraction at 0x0C reads 0x7FFF, and `irq_o` is low.
- R2: A write to an address in 0x00..0x14 is accepted when no transfer is pending. From the next cycle until the following tick, busy (status bit 10) is 1 and write-next (bit 9) is 0, and the target keeps its old value. At the first tick after acceptance the target takes the value, busy clears and write-complete (bit 8) sets.
- R3: A write to 0x00..0x14 issued while busy is 1 is dropped: write-error (status bit 7) sets and the pending transfer lands unchanged.
- R4: A write to 0x18 updates the enable word on the next clock edge, storing only bits 9, 8, 7 and 4 (other bits read 0), and it neither raises busy nor sets write-complete.
- R5: Reading the status word (read strobe with address 0x14) clears write-complete at that clock edge; if a transfer completes at the same edge, write-complete ends up set.
- R6: The counter advances by one on a tick only when control bit 3 is 1 and the counter has been written at least once since reset. 0x00 reads counter bits 46:15 and 0x04 reads bits 14:0 zero-extended, with the fraction carrying into the seconds.
- R7: The clock-alarm flag (status bit 4) sets on the tick where the counter advances onto the alarm value, which is alarm seconds (0x08) over alarm fraction bits 14:0 (0x0C).
- R8: A status write lands through the slow path like any other, and when it lands each 1 in bit 7, 4 or 1 of its data clears that flag. Until then the flags stay set.
- R9: `irq_o` is high exactly when some bit among 9, 8, 7 and 4 is set both in the status word and in the enable word.
- R10: A counter write that lands on a tick replaces the counter value in place of that tick's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe marking each slow-domain 32 kHz edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (used for the status read side effect) |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe with idle cycles between strobes, and that read and write strobes are never raised in the same cycle. They also assume that inputs change only away from the rising clock edge. The bench drives each stimulus at the falling edge. It raises the tick only through a task that holds it for exactly one cycle, and it never combines a bus write with a read. Samples are taken at the falling edge, so the side-effect-free peeks use a low read strobe and do not disturb write-complete.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned BUS_AW = 5;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] A_SEC      = 5'h00;
    localparam logic [BUS_AW-1:0] A_FRAC     = 5'h04;
    localparam logic [BUS_AW-1:0] A_ALM_SEC  = 5'h08;
    localparam logic [BUS_AW-1:0] A_ALM_FRAC = 5'h0C;
    localparam logic [BUS_AW-1:0] A_CTRL     = 5'h10;
    localparam logic [BUS_AW-1:0] A_STAT     = 5'h14;
    localparam logic [BUS_AW-1:0] A_IEN      = 5'h18;

    localparam int unsigned B_BUSY = 10;
    localparam int unsigned B_NEXT = 9;
    localparam int unsigned B_DONE = 8;
    localparam int unsigned B_WERR = 7;
    localparam int unsigned B_ALRM = 4;
    localparam int unsigned B_NVAL = 1;
    localparam int unsigned B_RUN  = 3;

    localparam logic [BUS_DW-1:0] IEN_MASK =
        (BUS_DW'(1) << B_NEXT) | (BUS_DW'(1) << B_DONE) |
        (BUS_DW'(1) << B_WERR) | (BUS_DW'(1) << B_ALRM);

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } slow_wr_t;
endpackage

// File: rtl/rtc_wr_bridge.sv
module rtc_wr_bridge
    import rtc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [BUS_DW-1:0] data_i,
    output logic              busy_o,
    output logic              apply_o,
    output logic              drop_o,
    output slow_wr_t          apply_wr_o
);
    typedef struct packed {
        logic     busy;
        slow_wr_t wr;
    } br_st_t;

    br_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        drop_o  = 1'b0;
        apply_o = s_q.busy && tick_i;
        if (apply_o) s_d.busy = 1'b0;
        if (req_i) begin
            if (s_q.busy) begin
                drop_o = 1'b1;
            end else begin
                s_d.busy    = 1'b1;
                s_d.wr.addr = addr_i;
                s_d.wr.data = data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o     = s_q.busy;
    assign apply_wr_o = s_q.wr;

    AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i) |=> busy_o); // R2
    AST_DROP_KEEPS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_o |=> $stable(apply_wr_o)); // R3
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W = 47
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             apply_i,
    input  slow_wr_t         wr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] alm_o,
    output logic             run_o,
    output logic             hit_o
);
    localparam int unsigned FRAC_W = CNT_W - BUS_DW;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alm;
        logic             run;
        logic             seen;
    } tk_st_t;

    tk_st_t s_d, s_q;
    logic [CNT_W-1:0] cnt_nx;
    logic step, cnt_wr;

    always_comb begin
        s_d    = s_q;
        hit_o  = 1'b0;
        cnt_nx = s_q.cnt + CNT_W'(1);
        step   = s_q.run && s_q.seen && tick_i;
        cnt_wr = apply_i && ((wr_i.addr == A_SEC) || (wr_i.addr == A_FRAC));
        if (apply_i) begin
            case (wr_i.addr)
                A_SEC: begin
                    s_d.cnt[CNT_W-1:FRAC_W] = wr_i.data;
                    s_d.seen = 1'b1;
                end
                A_FRAC: begin
                    s_d.cnt[FRAC_W-1:0] = wr_i.data[FRAC_W-1:0];
                    s_d.seen = 1'b1;
                end
                A_ALM_SEC:  s_d.alm[CNT_W-1:FRAC_W] = wr_i.data;
                A_ALM_FRAC: s_d.alm[FRAC_W-1:0]     = wr_i.data[FRAC_W-1:0];
                A_CTRL:     s_d.run                 = wr_i.data[B_RUN];
                default: ;
            endcase
        end
        if (step && !cnt_wr) begin
            s_d.cnt = cnt_nx;
            hit_o   = (cnt_nx == s_q.alm);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt  <= '0;
            s_q.alm  <= '1;
            s_q.run  <= 1'b0;
            s_q.seen <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign alm_o = s_q.alm;
    assign run_o = s_q.run;

    AST_STILL_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_o && !cnt_wr) |=> $stable(cnt_o)); // R6
    AST_WRITE_BEATS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i && wr_i.addr == A_FRAC) |=>
        (cnt_o[FRAC_W-1:0] == $past(wr_i.data[FRAC_W-1:0]))); // R10
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
    import rtc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              busy_i,
    input  logic              apply_i,
    input  slow_wr_t          wr_i,
    input  logic              drop_i,
    input  logic              hit_i,
    input  logic              stat_rd_i,
    input  logic              ien_wr_i,
    input  logic [BUS_DW-1:0] ien_data_i,
    output logic [BUS_DW-1:0] status_o,
    output logic [BUS_DW-1:0] ien_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              done;
        logic              werr;
        logic              alrm;
        logic              nval;
        logic [BUS_DW-1:0] ien;
    } fl_st_t;

    fl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stat_rd_i) s_d.done = 1'b0;
        if (apply_i && (wr_i.addr == A_STAT)) begin
            if (wr_i.data[B_WERR]) s_d.werr = 1'b0;
            if (wr_i.data[B_ALRM]) s_d.alrm = 1'b0;
            if (wr_i.data[B_NVAL]) s_d.nval = 1'b0;
        end
        if (apply_i)  s_d.done = 1'b1;
        if (drop_i)   s_d.werr = 1'b1;
        if (hit_i)    s_d.alrm = 1'b1;
        if (ien_wr_i) s_d.ien  = ien_data_i & IEN_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.nval <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_o         = '0;
        status_o[B_BUSY] = busy_i;
        status_o[B_NEXT] = !busy_i;
        status_o[B_DONE] = s_q.done;
        status_o[B_WERR] = s_q.werr;
        status_o[B_ALRM] = s_q.alrm;
        status_o[B_NVAL] = s_q.nval;
    end

    assign ien_o = s_q.ien;
    assign irq_o = |(status_o & s_q.ien);

    AST_READ_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd_i && !apply_i) |=> !status_o[B_DONE]); // R5
    AST_NVAL_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[B_NVAL]) |-> $past(apply_i)); // R8
    AST_DROP_FLAGS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_i |=> status_o[B_WERR]); // R3
endmodule

// File: rtl/rtc_lp_regs.sv
module rtc_lp_regs
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W = 47
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned FRAC_W = CNT_W - BUS_DW;

    logic             slow_req, ien_wr, stat_rd;
    logic             busy, apply, drop, hit, run;
    slow_wr_t         apply_wr;
    logic [CNT_W-1:0] cnt, alm;
    logic [BUS_DW-1:0] status, ien;

    always_comb begin
        slow_req = bus_wr_i && (bus_addr_i inside {A_SEC, A_FRAC, A_ALM_SEC,
                                                   A_ALM_FRAC, A_CTRL, A_STAT});
        ien_wr   = bus_wr_i && (bus_addr_i == A_IEN);
        stat_rd  = bus_rd_i && (bus_addr_i == A_STAT);
    end

    rtc_wr_bridge u_bridge (
        .clk_i, .rst_ni, .tick_i,
        .req_i      (slow_req),
        .addr_i     (bus_addr_i),
        .data_i     (bus_wdata_i),
        .busy_o     (busy),
        .apply_o    (apply),
        .drop_o     (drop),
        .apply_wr_o (apply_wr)
    );

    rtc_timekeeper #(.CNT_W(CNT_W)) u_time (
        .clk_i, .rst_ni, .tick_i,
        .apply_i (apply),
        .wr_i    (apply_wr),
        .cnt_o   (cnt),
        .alm_o   (alm),
        .run_o   (run),
        .hit_o   (hit)
    );

    rtc_flags u_flags (
        .clk_i, .rst_ni,
        .busy_i     (busy),
        .apply_i    (apply),
        .wr_i       (apply_wr),
        .drop_i     (drop),
        .hit_i      (hit),
        .stat_rd_i  (stat_rd),
        .ien_wr_i   (ien_wr),
        .ien_data_i (bus_wdata_i),
        .status_o   (status),
        .ien_o      (ien),
        .irq_o      (irq_o)
    );

    always_comb begin
        case (bus_addr_i)
            A_SEC:      bus_rdata_o = cnt[CNT_W-1:FRAC_W];
            A_FRAC:     bus_rdata_o = BUS_DW'(cnt[FRAC_W-1:0]);
            A_ALM_SEC:  bus_rdata_o = alm[CNT_W-1:FRAC_W];
            A_ALM_FRAC: bus_rdata_o = BUS_DW'(alm[FRAC_W-1:0]);
            A_CTRL:     bus_rdata_o = BUS_DW'(run) << B_RUN;
            A_STAT:     bus_rdata_o = status;
            A_IEN:      bus_rdata_o = ien;
            default:    bus_rdata_o = '0;
        endcase
    end

    AST_DONE_AT_LANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy) |-> status[B_DONE]); // R2
    AST_IEN_SKIPS_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien_wr && !busy) |=> !$rose(status[B_DONE])); // R4
    AST_ALARM_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> status[B_ALRM]); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien == '0) |-> !irq_o); // R9
endmodule

// File: tb/rtc_lp_regs_tb.sv
module rtc_lp_regs_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int errs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_lp_regs dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 0; rd = 0; tick = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic read_stat(output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = 5'h14;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        peek(5'h14, v); chk("R1 status", v, 32'h202);
        peek(5'h10, v); chk("R1 control", v, 0);
        peek(5'h18, v); chk("R1 enable", v, 0);
        peek(5'h00, v); chk("R1 seconds", v, 0);
        peek(5'h04, v); chk("R1 fraction", v, 0);
        peek(5'h08, v); chk("R1 alarm seconds", v, 32'hFFFF_FFFF);
        peek(5'h0C, v); chk("R1 alarm fraction", v, 32'h7FFF);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_slow_write();
        logic [31:0] v;
        do_reset();
        bus_write(5'h00, 32'd5);
        peek(5'h14, v); chk("R2 busy status", v, 32'h402);
        peek(5'h00, v); chk("R2 old value kept", v, 0);
        pulse_tick();
        peek(5'h00, v); chk("R2 landed value", v, 32'd5);
        peek(5'h14, v); chk("R2 done status", v, 32'h302);
        read_stat(v);   chk("R5 read returns done", v, 32'h302);
        peek(5'h14, v); chk("R5 done cleared", v, 32'h202);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        do_reset();
        bus_write(5'h08, 32'd100);
        bus_write(5'h08, 32'd7);
        peek(5'h14, v); chk("R3 error while busy", v, 32'h482);
        pulse_tick();
        peek(5'h08, v); chk("R3 first write kept", v, 32'd100);
        peek(5'h14, v); chk("R3 status after landing", v, 32'h382);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        do_reset();
        bus_write(5'h08, 32'd1);
        bus_write(5'h08, 32'd2);
        pulse_tick();
        bus_write(5'h14, 32'h92);
        peek(5'h14, v); chk("R8 flags held before tick", v, 32'h582);
        pulse_tick();
        peek(5'h14, v); chk("R8 flags cleared", v, 32'h300);
    endtask

    task automatic t_ien();
        logic [31:0] v;
        do_reset();
        bus_write(5'h18, 32'hFFFF_FFFF);
        peek(5'h18, v); chk("R4 enable masked", v, 32'h390);
        peek(5'h14, v); chk("R4 no busy no done", v, 32'h202);
        chk("R9 irq on write-next", 32'(irq), 1);
        bus_write(5'h18, 32'h10);
        peek(5'h14, v);
        chk("R9 irq off", 32'(irq), 0);
        bus_write(5'h18, 32'h100);
        bus_write(5'h10, 32'h0);
        pulse_tick();
        peek(5'h14, v);
        chk("R9 irq on done", 32'(irq), 1);
        read_stat(v);
        peek(5'h14, v);
        chk("R9 R5 irq off after read", 32'(irq), 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        bus_write(5'h10, 32'h8);
        pulse_tick();
        peek(5'h10, v); chk("R6 control readback", v, 32'h8);
        pulse_tick(); pulse_tick(); pulse_tick();
        peek(5'h04, v); chk("R6 unwritten counter frozen", v, 0);
        bus_write(5'h04, 32'h7FFE);
        pulse_tick();
        peek(5'h04, v); chk("R10 write replaces step", v, 32'h7FFE);
        pulse_tick();
        peek(5'h04, v); chk("R6 step", v, 32'h7FFF);
        pulse_tick();
        peek(5'h04, v); chk("R6 fraction wraps", v, 0);
        peek(5'h00, v); chk("R6 carry into seconds", v, 1);
        bus_write(5'h00, 32'd9);
        pulse_tick();
        peek(5'h00, v); chk("R10 seconds write", v, 9);
        peek(5'h04, v); chk("R10 no step on landing", v, 0);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        do_reset();
        bus_write(5'h08, 32'd0); pulse_tick();
        bus_write(5'h0C, 32'd3); pulse_tick();
        bus_write(5'h10, 32'h8); pulse_tick();
        bus_write(5'h04, 32'd0); pulse_tick();
        bus_write(5'h18, 32'h10);
        pulse_tick(); pulse_tick();
        peek(5'h14, v); chk("R7 not yet", v & 32'h10, 0);
        chk("R7 irq low before", 32'(irq), 0);
        pulse_tick();
        peek(5'h14, v); chk("R7 alarm flag", v & 32'h10, 32'h10);
        chk("R7 R9 irq on alarm", 32'(irq), 1);
        bus_write(5'h14, 32'h10);
        peek(5'h14, v); chk("R8 alarm held before tick", v & 32'h10, 32'h10);
        pulse_tick();
        peek(5'h14, v); chk("R8 alarm cleared", v & 32'h10, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        do_reset();
        bus_write(5'h10, 32'h0);
        @(negedge clk);
        tick = 1'b1; rd = 1'b1; addr = 5'h14;
        #1 v = rdata;
        chk("R5 done low before landing", v & 32'h100, 0);
        @(negedge clk);
        tick = 1'b0; rd = 1'b0;
        peek(5'h14, v); chk("R5 set wins over read", v & 32'h100, 32'h100);
    endtask

    initial begin
        t_reset_state();
        t_slow_write();
        t_drop();
        t_w1c();
        t_ien();
        t_count();
        t_alarm();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule